// File: doc/BRIEF.md
# Dual-Source Handshake FIFO

This block is a synchronous first-in first-out buffer with a parameterised word width and depth. It has two write data buses of the same width. On every accepted write, a single select input decides which bus supplies the stored word. A producer raises a write request and sees a write acknowledge that is high while the buffer has a free slot. A consumer raises a read request and sees a read acknowledge that is high while at least one word is held. The oldest held word is always on the read bus.

The read path is first-word fall-through. The read bus is driven combinationally from the storage slot at the read pointer, so the consumer sees the head word in the same cycle the read acknowledge is high. A synchronous, active-high reset empties the buffer. It clears both pointers and the occupancy count. It does not clear the storage array.

Top module: `dual_bus_fifo`

## Requirements
- R1: In the cycle after reset is released, rd_ok is 0 and wr_ok is 1. The buffer holds no words.
- R2: An accepted push stores wdata_a when bus_sel is 0 and stores wdata_b when bus_sel is 1. The other bus is not stored.
- R3: Words leave in the order they were accepted. While rd_ok is 1, rdata equals the oldest held word with no clock delay.
- R4: rd_ok is 1 exactly when the occupancy is non-zero. wr_ok is 1 exactly when the occupancy is below DEPTH.
- R5: On a rising edge, wr_req with wr_ok stores one word and rd_req with rd_ok removes one word. If both happen, the occupancy is unchanged.
- R6: When the buffer is full and wr_req and rd_req are both high, the head word is removed and the new word is stored in the same edge. The buffer stays full.
- R7: When the buffer is empty and wr_req and rd_req are both high, only the push takes effect. The occupancy becomes 1.
- R8: When the buffer is full, wr_req without rd_req is ignored. The held words and their order are unchanged.
- R9: When the buffer is empty, rd_req without wr_req is ignored. The buffer stays empty.
- R10: Both pointers wrap past the last slot, so ordering holds across many more than DEPTH transfers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset; empties the buffer |
| rd_req | input | 1 | Read request |
| wr_req | input | 1 | Write request |
| rd_ok | output | 1 | Read acknowledge: buffer not empty |
| wr_ok | output | 1 | Write acknowledge: buffer not full |
| bus_sel | input | 1 | Write source: 0 selects wdata_a, 1 selects wdata_b |
| wdata_a | input | WIDTH | First write data bus |
| wdata_b | input | WIDTH | Second write data bus |
| rdata | output | WIDTH | Oldest held word (fall-through) |

## Verification
State changes appear one rising edge after the request: occupancy, the acknowledges and the head word all move together at that edge. rdata follows the head slot combinationally, with no further delay. The bench drives every input on the falling edge and first compares rd_ok, wr_ok and rdata against a queue model of the state after the previous rising edge. It then applies the push and pop rules to that model for the coming edge. This places every comparison half a period after the edge that caused it.

// File: rtl/dbf_pkg.sv
package dbf_pkg;
   typedef enum logic {SRC_A = 1'b0, SRC_B = 1'b1} src_e;

   function automatic int unsigned idx_bits(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/dbf_src_mux.sv
module dbf_src_mux #(
   parameter int unsigned WIDTH = 32
) (
   input  logic             sel,
   input  logic [WIDTH-1:0] bus_a,
   input  logic [WIDTH-1:0] bus_b,
   output logic [WIDTH-1:0] word
);
   import dbf_pkg::*;

   src_e src;
   assign src = src_e'(sel);

   always_comb begin
      unique case (src)
         SRC_B:   word = bus_b;
         default: word = bus_a;
      endcase
   end
endmodule

// File: rtl/dbf_ctrl.sv
module dbf_ctrl #(
   parameter int unsigned DEPTH = 8,
   localparam int unsigned PW = dbf_pkg::idx_bits(DEPTH),
   localparam int unsigned CW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          rd_req,
   input  logic          wr_req,
   output logic          push,
   output logic          pop,
   output logic [PW-1:0] wptr,
   output logic [PW-1:0] rptr,
   output logic          not_empty,
   output logic          not_full
);
   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
   localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);
   localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

   logic [CW-1:0] count;
   logic [PW-1:0] wptr_nx, rptr_nx;

   assign not_empty = (count != '0);
   assign not_full  = (count != FULL_CNT);
   // a pop frees a slot in the same edge, so a full buffer may also take a push
   assign pop  = rd_req && not_empty;
   assign push = wr_req && (not_full || rd_req);

   generate
      if (POW2) begin : g_wrap_free
         assign wptr_nx = wptr + 1'b1;
         assign rptr_nx = rptr + 1'b1;
      end else begin : g_wrap_cmp
         assign wptr_nx = (wptr == LAST_IDX) ? '0 : wptr + 1'b1;
         assign rptr_nx = (rptr == LAST_IDX) ? '0 : rptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (push) wptr <= wptr_nx;
         if (pop)  rptr <= rptr_nx;
         unique case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   p_reset_empty_r1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!not_empty && not_full));
   p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
      count <= FULL_CNT);
   p_full_both_r6: assert property (@(posedge clk) disable iff (rst)
      (!not_full && wr_req && rd_req) |=> (!not_full && rptr != $past(rptr)));
   p_empty_both_r7: assert property (@(posedge clk) disable iff (rst)
      (!not_empty && wr_req && rd_req) |=> (count == CW'(1)));
   p_full_hold_r8: assert property (@(posedge clk) disable iff (rst)
      (!not_full && wr_req && !rd_req) |=> ($stable(wptr) && $stable(rptr) && !not_full));
   p_empty_hold_r9: assert property (@(posedge clk) disable iff (rst)
      (!not_empty && rd_req && !wr_req) |=> ($stable(rptr) && !not_empty));
endmodule

// File: rtl/dbf_store.sv
module dbf_store #(
   parameter int unsigned WIDTH = 32,
   parameter int unsigned DEPTH = 8,
   localparam int unsigned PW = dbf_pkg::idx_bits(DEPTH)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             we,
   input  logic [PW-1:0]    waddr,
   input  logic [WIDTH-1:0] wword,
   input  logic [PW-1:0]    raddr,
   output logic [WIDTH-1:0] rword
);
   logic [WIDTH-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wword;
   end

   assign rword = mem[raddr];

   p_store_word_r2: assert property (@(posedge clk) disable iff (rst)
      we |=> (mem[$past(waddr)] == $past(wword)));
endmodule

// File: rtl/dual_bus_fifo.sv
module dual_bus_fifo #(
   parameter int unsigned WIDTH = 32,
   parameter int unsigned DEPTH = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             rd_req,
   input  logic             wr_req,
   output logic             rd_ok,
   output logic             wr_ok,
   input  logic             bus_sel,
   input  logic [WIDTH-1:0] wdata_a,
   input  logic [WIDTH-1:0] wdata_b,
   output logic [WIDTH-1:0] rdata
);
   localparam int unsigned PW = dbf_pkg::idx_bits(DEPTH);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("dual_bus_fifo: DEPTH must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("dual_bus_fifo: WIDTH must be at least 1");
      end
   endgenerate

   logic             push, pop;
   logic [PW-1:0]    wptr, rptr;
   logic [WIDTH-1:0] in_word;

   dbf_src_mux #(.WIDTH(WIDTH)) u_mux (
      .sel   (bus_sel),
      .bus_a (wdata_a),
      .bus_b (wdata_b),
      .word  (in_word)
   );

   dbf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk       (clk),
      .rst       (rst),
      .rd_req    (rd_req),
      .wr_req    (wr_req),
      .push      (push),
      .pop       (pop),
      .wptr      (wptr),
      .rptr      (rptr),
      .not_empty (rd_ok),
      .not_full  (wr_ok)
   );

   dbf_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
      .clk   (clk),
      .rst   (rst),
      .we    (push),
      .waddr (wptr),
      .wword (in_word),
      .raddr (rptr),
      .rword (rdata)
   );

   p_pop_needs_word_r4: assert property (@(posedge clk) disable iff (rst)
      pop |-> rd_ok);
endmodule

// File: tb/dual_bus_fifo_test.sv
module dual_bus_fifo_test;
   localparam int W = 32;
   localparam int D = 8;

   logic clk = 1'b0;
   logic rst, rd_req, wr_req, bus_sel;
   logic [W-1:0] wdata_a, wdata_b;
   logic rd_ok, wr_ok;
   logic [W-1:0] rdata;

   int total = 0;
   int bad = 0;
   bit done = 0;
   logic [W-1:0] model [$];

   always #5 clk = ~clk;

   dual_bus_fifo #(.WIDTH(W), .DEPTH(D)) uut (
      .clk(clk), .rst(rst), .rd_req(rd_req), .wr_req(wr_req),
      .rd_ok(rd_ok), .wr_ok(wr_ok), .bus_sel(bus_sel),
      .wdata_a(wdata_a), .wdata_b(wdata_b), .rdata(rdata)
   );

   function automatic bit exp_push(input bit wr, input bit rd, input int cnt);
      return wr && (cnt < D || rd);
   endfunction

   function automatic bit exp_pop(input bit rd, input int cnt);
      return rd && cnt > 0;
   endfunction

   task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // compare outputs with the model, then drive and advance the model
   task automatic step(input bit wr, input bit rd, input bit sel,
                       input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
      bit pu, po;
      @(negedge clk);
      chk({tag, " rd_ok (R4)"}, W'(rd_ok), W'(model.size() > 0));
      chk({tag, " wr_ok (R4)"}, W'(wr_ok), W'(model.size() < D));
      if (model.size() > 0) chk({tag, " rdata (R3)"}, rdata, model[0]);
      wr_req = wr; rd_req = rd; bus_sel = sel; wdata_a = a; wdata_b = b;
      pu = exp_push(wr, rd, model.size());
      po = exp_pop(rd, model.size());
      if (po) void'(model.pop_front());
      if (pu) model.push_back(sel ? b : a);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      rst = 1'b1; rd_req = 0; wr_req = 0; bus_sel = 0; wdata_a = '0; wdata_b = '0;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      // R1: reset state
      chk("R1 rd_ok after reset", W'(rd_ok), '0);
      chk("R1 wr_ok after reset", W'(wr_ok), W'(1));

      // R9: read on empty ignored
      step(0, 1, 0, 32'h1, 32'h2, "R9");
      step(0, 0, 0, 32'h1, 32'h2, "R9");
      // R7: both on empty, only push
      step(1, 1, 1, 32'hAAAA0000, 32'hBBBB0000, "R7");
      step(0, 1, 0, 0, 0, "R7");
      step(0, 0, 0, 0, 0, "R7");
      // R2: fill, alternating bus select
      for (int i = 0; i < D; i++)
         step(1, 0, i[0], 32'hA000 + i, 32'hB000 + i, "R2");
      // R8: write while full ignored
      step(1, 0, 0, 32'hDEAD, 32'hBEEF, "R8");
      step(1, 0, 1, 32'hDEAD, 32'hBEEF, "R8");
      // R6: both while full
      step(1, 1, 1, 32'h0, 32'hC0DE, "R6");
      step(1, 1, 0, 32'hF00D, 32'h0, "R6");
      step(0, 0, 0, 0, 0, "R6");
      // drain, checking order (R3)
      for (int i = 0; i < D + 1; i++) step(0, 1, 0, 0, 0, "R3");
      step(0, 0, 0, 0, 0, "R9");

      // R5, R10: random phases around empty and full
      for (int i = 0; i < 3000; i++) begin
         int phase;
         bit wr, rd;
         phase = (i / 40) % 3;
         wr = (phase == 0) ? ($urandom % 4 != 0) : (phase == 1) ? ($urandom % 4 == 0) : $urandom[0];
         rd = (phase == 1) ? ($urandom % 4 != 0) : (phase == 0) ? ($urandom % 4 == 0) : $urandom[0];
         step(wr, rd, $urandom[0], $urandom, $urandom, (i % 2 == 0) ? "R5" : "R10");
      end
      step(0, 0, 0, 0, 0, "R10");

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule